// File: doc/BRIEF.md
# DMA Channel Register Write Guard

This block holds the programming registers of one DMA channel that is split into two sub-channels, A and B, and decides bit by bit which parts of a register write may land. Two gate bits in a write-enable register, the identity of the bus master issuing the write, and the channel's full-address mode flag together form a per-bit write mask. Protected bits keep their value while the unprotected bits of the same word take the new data.

The address, I/O address and count registers are never protected. The transfer engine reads the held values from dedicated output ports. Software and the transfer helper read them back through a registered read port.

Top module: `dma_wprot`

## Requirements
- R1: After reset every register, including the write-enable register, holds zero.
- R2: The write-enable register sits at address 0. Bit 0 is gate A and bit 1 is gate B; bits 15..2 read 0. A write with `mst`=0 (CPU) updates it. A write with `mst`=1 (transfer helper) leaves it unchanged.
- R3: With gate A at 0, writes leave control register A (address 1) unchanged. They also leave bits 8, 4 and 0 of the bank control register (address 3) unchanged.
- R4: With gate B at 0, writes leave control register B (address 2) unchanged. They also leave bits 9, 5 and 1 of the bank control register and bit 4 of the transfer control register (address 4) unchanged.
- R5: Helper writes never change bank control bits 15..12. CPU writes change those bits whatever the gates hold.
- R6: A single helper write of 1 to bank control bits 7..4 sets each of those bits whose gate allows it. No earlier read is needed.
- R7: Address low/high (5, 6), I/O address (7) and count (8) take every write from either master, whatever the gates hold.
- R8: While bank control bit 12 (full-address mode) is 1, bank bits 8, 4 and 0 change only when both gates are 1.
- R9: In a partly protected word, the allowed bits take the write data and the protected bits keep their old value. Both happen at the same clock edge, and a read issued in the next cycle shows the merged value.
- R10: A read with `rd_en` at a clock edge presents that register's contents on `rdata` after the edge, and `rdata` holds otherwise. The result is the same for any gate setting. Unmapped addresses (9..15) read 0, and writes to them change nothing.
- R11: `be[0]` enables bits 7..0 and `be[1]` enables bits 15..8. Control registers A and B and the transfer control register are 8 bits wide, and their upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Register address |
| wdata | input | 16 | Write data |
| be | input | 2 | Byte enables |
| mst | input | 1 | Master ID: 0 CPU, 1 transfer helper |
| rdata | output | 16 | Registered read data |
| ctl_a_o | output | 8 | Control register A |
| ctl_b_o | output | 8 | Control register B |
| bank_o | output | 16 | Bank control register |
| tctl_o | output | 8 | Transfer control register |
| mar_o | output | 32 | Memory address |
| ioar_o | output | 16 | I/O address |
| etcr_o | output | 16 | Transfer count |

## Verification
A write presented before a rising edge is already in the register after that edge, so it shows on the register outputs and in the next read. A read issued at one edge places its data on `rdata` right after that edge. The bench drives both strobes at the falling edge, lets exactly one rising edge pass, and samples at the following falling edge. The reference model is updated in the same step as the write, using the gate and mode values from before the write. Every read is compared against that model, and this includes the case where a write changes the mode bit itself.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int DW     = 16;
  localparam int NREG   = 9;
  localparam int NLANE  = DW / 8;

  localparam int R_WEN  = 0;
  localparam int R_CTLA = 1;
  localparam int R_CTLB = 2;
  localparam int R_BANK = 3;
  localparam int R_TCTL = 4;
  localparam int R_MARL = 5;
  localparam int R_MARH = 6;
  localparam int R_IOAR = 7;
  localparam int R_ETCR = 8;

  // full-address mode flag inside the bank control word
  localparam int BK_FAM = 12;

  // implemented bits of each word
  function automatic logic [DW-1:0] valid_bits(input int idx);
    case (idx)
      R_WEN:                 valid_bits = 16'h0003;
      R_CTLA, R_CTLB, R_TCTL: valid_bits = 16'h00FF;
      default:               valid_bits = 16'hFFFF;
    endcase
  endfunction
endpackage

// File: rtl/wp_rst_sync.sv
module wp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/wp_mask_gen.sv
module wp_mask_gen
  import wp_pkg::*;
(
  input  logic [1:0]                 wen,
  input  logic                       fam,
  input  logic                       helper,
  input  logic [NLANE-1:0]           be,
  output logic [NREG-1:0][DW-1:0]    wmask
);
  logic [DW-1:0] lane;
  logic          gate_a_bank;
  logic          gate_b;
  logic [DW-1:0] bank_p;
  logic [DW-1:0] tctl_p;

  always_comb begin
    for (int i = 0; i < NLANE; i++) lane[i*8 +: 8] = {8{be[i]}};
  end

  always_comb begin
    gate_b      = wen[1];
    // in full-address mode sub-channel A bank bits need both gates
    gate_a_bank = wen[0] & (~fam | wen[1]);

    bank_p        = '1;
    bank_p[15:12] = helper ? 4'b0000 : 4'b1111;
    bank_p[8]     = gate_a_bank;
    bank_p[4]     = gate_a_bank;
    bank_p[0]     = gate_a_bank;
    bank_p[9]     = gate_b;
    bank_p[5]     = gate_b;
    bank_p[1]     = gate_b;

    tctl_p    = '1;
    tctl_p[4] = gate_b;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == R_WEN) begin : g_wen
      assign wmask[g] = lane & valid_bits(g) & {DW{~helper}};
    end else if (g == R_CTLA) begin : g_ca
      assign wmask[g] = lane & valid_bits(g) & {DW{wen[0]}};
    end else if (g == R_CTLB) begin : g_cb
      assign wmask[g] = lane & valid_bits(g) & {DW{wen[1]}};
    end else if (g == R_BANK) begin : g_bk
      assign wmask[g] = lane & valid_bits(g) & bank_p;
    end else if (g == R_TCTL) begin : g_tc
      assign wmask[g] = lane & valid_bits(g) & tctl_p;
    end else begin : g_open
      assign wmask[g] = lane & valid_bits(g);
    end
  end
endmodule

// File: rtl/wp_word.sv
module wp_word #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nx;

  always_comb q_nx = (q_r & ~mask) | (wdata & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (we) q_r <= q_nx;
  end

  assign q = q_r;
endmodule

// File: rtl/wp_rd_port.sv
module wp_rd_port #(
  parameter int AW   = 4,
  parameter int NW   = 9,
  parameter int W    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic [AW-1:0]        addr,
  input  logic [NW-1:0][W-1:0] words,
  output logic [W-1:0]         rdata
);
  logic [W-1:0] sel_d;
  logic [W-1:0] rd_q;

  always_comb begin
    sel_d = '0;
    for (int i = 0; i < NW; i++) begin
      if (addr == AW'(i)) sel_d = words[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= sel_d;
  end

  assign rdata = rd_q;
endmodule

// File: rtl/dma_wprot.sv
module dma_wprot
  import wp_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  input  logic [1:0]    be,
  input  logic          mst,
  output logic [15:0]   rdata,
  output logic [7:0]    ctl_a_o,
  output logic [7:0]    ctl_b_o,
  output logic [15:0]   bank_o,
  output logic [7:0]    tctl_o,
  output logic [31:0]   mar_o,
  output logic [15:0]   ioar_o,
  output logic [15:0]   etcr_o
);
  logic                    rst_s_n;
  logic [NREG-1:0][DW-1:0] words;
  logic [NREG-1:0][DW-1:0] wmask;
  logic [NREG-1:0]         wsel;
  logic [1:0]              wen_q;

  wp_rst_sync #(.STAGES(2)) u_rs (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  assign wen_q = words[R_WEN][1:0];

  wp_mask_gen u_mg (
    .wen    (wen_q),
    .fam    (words[R_BANK][BK_FAM]),
    .helper (mst),
    .be     (be),
    .wmask  (wmask)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_word
    assign wsel[g] = wr_en && (addr == AW'(g));
    wp_word #(.W(DW)) u_w (
      .clk   (clk),
      .rst_n (rst_s_n),
      .we    (wsel[g]),
      .mask  (wmask[g]),
      .wdata (wdata),
      .q     (words[g])
    );
  end

  wp_rd_port #(.AW(AW), .NW(NREG), .W(DW)) u_rd (
    .clk   (clk),
    .rst_n (rst_s_n),
    .rd_en (rd_en),
    .addr  (addr),
    .words (words),
    .rdata (rdata)
  );

  assign ctl_a_o = words[R_CTLA][7:0];
  assign ctl_b_o = words[R_CTLB][7:0];
  assign bank_o  = words[R_BANK];
  assign tctl_o  = words[R_TCTL][7:0];
  assign mar_o   = {words[R_MARH], words[R_MARL]};
  assign ioar_o  = words[R_IOAR];
  assign etcr_o  = words[R_ETCR];
endmodule

// File: rtl/dma_wprot_chk.sv
module dma_wprot_chk
  import wp_pkg::*;
#(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_s_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [15:0]   wdata,
  input logic [1:0]    be,
  input logic          mst,
  input logic [1:0]    wen_q,
  input logic [15:0]   rdata,
  input logic [7:0]    ctl_a_o,
  input logic [7:0]    ctl_b_o,
  input logic [15:0]   bank_o,
  input logic [7:0]    tctl_o,
  input logic [31:0]   mar_o,
  input logic [15:0]   etcr_o
);
  // R2
  wen_helper_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_en && mst && addr == AW'(R_WEN)) |=> $stable(wen_q));

  // R3
  ctla_lock_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_en && !wen_q[0] && addr == AW'(R_CTLA)) |=> $stable(ctl_a_o));

  // R4
  ctlb_lock_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_en && !wen_q[1] && addr == AW'(R_CTLB)) |=> $stable(ctl_b_o));

  // R4
  tctl_lock_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_en && !wen_q[1] && addr == AW'(R_TCTL)) |=> $stable(tctl_o[4]));

  // R4
  bank_b_lock_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_en && !wen_q[1] && addr == AW'(R_BANK))
      |=> ($stable(bank_o[9]) && $stable(bank_o[5]) && $stable(bank_o[1])));

  // R5
  bank_hi_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_en && mst && addr == AW'(R_BANK)) |=> $stable(bank_o[15:12]));

  // R8
  fam_lock_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_en && bank_o[BK_FAM] && wen_q != 2'b11 && addr == AW'(R_BANK))
      |=> ($stable(bank_o[8]) && $stable(bank_o[4]) && $stable(bank_o[0])));

  // R7
  mar_open_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_en && be == 2'b11 && addr == AW'(R_MARL)) |=> (mar_o[15:0] == $past(wdata)));

  // R10
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_en && addr == AW'(R_ETCR)) |=> (rdata == $past(etcr_o)));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!rd_en) |=> $stable(rdata));
endmodule

bind dma_wprot dma_wprot_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst_s_n (rst_s_n),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wdata   (wdata),
  .be      (be),
  .mst     (mst),
  .wen_q   (wen_q),
  .rdata   (rdata),
  .ctl_a_o (ctl_a_o),
  .ctl_b_o (ctl_b_o),
  .bank_o  (bank_o),
  .tctl_o  (tctl_o),
  .mar_o   (mar_o),
  .etcr_o  (etcr_o)
);

// File: tb/sim_dma_wprot.sv
`timescale 1ns/1ps
module sim_dma_wprot;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        rd_en;
  logic [3:0]  addr;
  logic [15:0] wdata;
  logic [1:0]  be;
  logic        mst;
  logic [15:0] rdata;
  logic [7:0]  ctl_a_o, ctl_b_o, tctl_o;
  logic [15:0] bank_o, ioar_o, etcr_o;
  logic [31:0] mar_o;

  int checks;
  int failures;
  logic [15:0] mdl [9];

  dma_wprot #(.AW(4)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .be(be), .mst(mst), .rdata(rdata),
    .ctl_a_o(ctl_a_o), .ctl_b_o(ctl_b_o), .bank_o(bank_o), .tctl_o(tctl_o),
    .mar_o(mar_o), .ioar_o(ioar_o), .etcr_o(etcr_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int width_of(input int a);
    if (a == 0) return 2;
    if (a == 1 || a == 2 || a == 4) return 8;
    return 16;
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5/R6/R8/R9";
      4: return "R4/R9";
      default: return "R7/R11";
    endcase
  endfunction

  // behavioural reference: decide per bit whether the write may land
  function automatic void model_write(input bit m, input int a, input logic [15:0] d,
                                      input logic [1:0] b);
    logic [15:0] old_wen;
    logic        fam_now;
    old_wen = mdl[0];
    fam_now = mdl[3][12];
    if (a > 8) return;
    for (int k = 0; k < width_of(a); k++) begin
      bit ok;
      if (!b[k/8]) continue;
      ok = 1'b1;
      case (a)
        0: ok = (m == 1'b0);
        1: ok = old_wen[0];
        2: ok = old_wen[1];
        3: begin
          if (k >= 12) ok = (m == 1'b0);
          else if (k == 0 || k == 4 || k == 8)
            ok = old_wen[0] && (!fam_now || old_wen[1]);
          else if (k == 1 || k == 5 || k == 9) ok = old_wen[1];
        end
        4: if (k == 4) ok = old_wen[1];
        default: ok = 1'b1;
      endcase
      if (ok) mdl[a][k] = d[k];
    end
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit m, input int a, input logic [15:0] d, input logic [1:0] b);
    @(negedge clk);
    wr_en = 1'b1; mst = m; addr = 4'(a); wdata = d; be = b;
    model_write(m, a, d, b);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = 4'(a);
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic check_all();
    logic [15:0] v;
    for (int a = 0; a < 9; a++) begin
      rd(a, v);
      check(tag_of(a), v, mdl[a]);
    end
  endtask

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL R10 watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    checks = 0; failures = 0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; be = '0; mst = 1'b0;
    for (int a = 0; a < 9; a++) mdl[a] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset contents
    for (int a = 0; a < 9; a++) begin
      rd(a, v);
      check("R1", v, 16'h0000);
    end

    // R10 unmapped address: read 0, write ignored
    wr(1'b0, 12, 16'hFFFF, 2'b11);
    rd(12, v);
    check("R10", v, 16'h0000);
    check_all();

    // R6: helper sets enable bits 7..4 in one write with both gates open
    wr(1'b0, 0, 16'h0003, 2'b01);
    wr(1'b0, 3, 16'h0000, 2'b11);
    wr(1'b1, 3, 16'h00F0, 2'b01);
    rd(3, v);
    check("R6", v, 16'h00F0);
    // R5: helper cannot touch bits 15..12, CPU can
    wr(1'b1, 3, 16'hF0F0, 2'b11);
    rd(3, v);
    check("R5", v, 16'h00F0);
    wr(1'b0, 3, 16'h1000, 2'b11);
    rd(3, v);
    check("R5", v, 16'h1000);
    // R8: full-address mode, gate A alone is not enough
    wr(1'b0, 0, 16'h0001, 2'b01);
    wr(1'b1, 3, 16'h0111, 2'b11);
    rd(3, v);
    check("R8", v, 16'h1000);
    wr(1'b0, 0, 16'h0003, 2'b01);
    wr(1'b1, 3, 16'h0111, 2'b11);
    rd(3, v);
    check("R8", v, 16'h1111);
    // R9: partial merge with gate B closed
    wr(1'b0, 0, 16'h0001, 2'b01);
    wr(1'b0, 3, 16'h1FFF, 2'b11);
    rd(3, v);
    check("R9", v, 16'h1DDD);
    // R11: one byte lane only
    wr(1'b1, 8, 16'hABCD, 2'b10);
    rd(8, v);
    check("R11", v, 16'hAB00);
    // R2: helper cannot change the write-enable register
    wr(1'b1, 0, 16'h0002, 2'b01);
    rd(0, v);
    check("R2", v, 16'h0001);
    check_all();

    // exhaustive master x gate x mode sweep against the model (R3 R4 R7 R9 R10)
    for (int m = 0; m < 2; m++) begin
      for (int g = 0; g < 4; g++) begin
        for (int f = 0; f < 2; f++) begin
          for (int a = 0; a < 9; a++) begin
            for (int p = 0; p < 2; p++) begin
              logic [15:0] d;
              logic [1:0]  b;
              wr(1'b0, 0, 16'h0003, 2'b01);
              wr(1'b0, 3, {3'b000, f[0], 12'h000} | (16'($urandom) & 16'h0FFF), 2'b11);
              wr(1'b0, 0, 16'(g), 2'b01);
              d = (p == 0) ? ~mdl[a] : 16'($urandom);
              b = (p == 0) ? 2'b11 : 2'($urandom);
              wr(m[0], a, d, b);
              check_all();
            end
          end
        end
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule